// File: doc/BRIEF.md
# RV32I Integer Datapath: ALU, Branch Comparator and Next-PC Unit

This block holds the purely combinational integer arithmetic of a 32-bit RISC-V core. The ALU takes two operands and a 4-bit operation code. It returns a result for:
- addition and subtraction;
- the three bitwise logic functions;
- left, logical-right and arithmetic-right shifts;
- signed and unsigned set-less-than;
- a pass-through of the second operand, used for LUI.

AUIPC is formed by presenting the PC and the shifted immediate to the adder.

A separate branch comparator looks at two register values and the 3-bit branch condition field, and raises a taken flag. Both the ALU and the comparator take their less-than results from one shared compare unit. That unit derives the signed answer from the subtraction sign and from whether the operand signs disagree.

A next-PC unit produces the link value (PC+4) and the address of the next instruction. It covers sequential flow, conditional branches, direct jumps and register-indirect jumps. Decoding the instruction, sign-extending immediates, the register file and memory access all sit outside this block. All operands arrive already extended.

Top module: `rv_int_datapath`

## Requirements
- R1: With `alu_op` 0 the result is `alu_a + alu_b`, and with `alu_op` 1 it is `alu_a - alu_b`. Both wrap modulo 2^32, with no flag or trap.
- R2: `alu_op` 2 gives the bitwise AND of the operands, 3 gives the OR and 4 gives the XOR.
- R3: `alu_op` 5 shifts left, 6 shifts right filling with zeros, and 7 shifts right copying bit 31. The shift amount is only `alu_b[4:0]`, and the upper bits of `alu_b` have no effect.
- R4: `alu_op` 8 (signed) and 9 (unsigned) return 1 when `alu_a` is below `alu_b` and 0 otherwise. Both are correct for 0x80000000 against 0x7FFFFFFF. An immediate that is sign-extended before it reaches the ALU compares as a large unsigned value.
- R5: `alu_op` 10 returns `alu_b` unchanged, for LUI. Codes 11 to 15 return zero.
- R6: `br_taken` follows `br_cond`: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. Codes 010 and 011 are never taken.
- R7: Branch compares of 0x80000000 against 0x7FFFFFFF give the opposite signed and unsigned outcomes.
- R8: `pc_link` is always `pc + 4`.
- R9: `pc_kind` 0 selects `pc + 4`. `pc_kind` 1 selects `pc + pc_imm` when the branch is taken and `pc + 4` when it is not. `pc_kind` 2 selects `pc + pc_imm`.
- R10: `pc_kind` 3 selects `jump_base + pc_imm` with bit 0 forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_a | input | 32 | First ALU operand (register value or PC) |
| alu_b | input | 32 | Second ALU operand (register value or extended immediate) |
| alu_op | input | 4 | ALU operation code |
| alu_y | output | 32 | ALU result |
| br_a | input | 32 | First branch compare operand |
| br_b | input | 32 | Second branch compare operand |
| br_cond | input | 3 | Branch condition field |
| br_taken | output | 1 | Branch condition holds |
| pc | input | 32 | Current instruction address |
| pc_kind | input | 2 | Next-PC selection |
| pc_imm | input | 32 | Sign-extended branch, jump or indirect-jump offset |
| jump_base | input | 32 | Base register for indirect jumps |
| pc_next | output | 32 | Address of the next instruction |
| pc_link | output | 32 | Return address written to the destination register |

## Verification
The bench builds the block with its default width of 32 bits. At that width the shift amount is a 5-bit field, so shift operands of 0x21 and 0x3F show that the upper bits are discarded. The same width makes the 0x80000000 / 0x7FFFFFFF pair a true sign boundary for both the ALU and the branch compare. The derived 33-bit difference puts the unsigned borrow at bit 32, which is where the unsigned results of both compare paths come from.

// File: rtl/rvdp_pkg.sv
package rvdp_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_SHL   = 4'd5,
    OP_SHR   = 4'd6,
    OP_SHRA  = 4'd7,
    OP_LTS   = 4'd8,
    OP_LTU   = 4'd9,
    OP_PASSB = 4'd10
  } alu_op_e;

  typedef enum logic [2:0] {
    BC_EQ  = 3'b000,
    BC_NE  = 3'b001,
    BC_LT  = 3'b100,
    BC_GE  = 3'b101,
    BC_LTU = 3'b110,
    BC_GEU = 3'b111
  } br_cond_e;

  typedef enum logic [1:0] {
    PK_SEQ  = 2'd0,
    PK_BR   = 2'd1,
    PK_JAL  = 2'd2,
    PK_JALR = 2'd3
  } pc_kind_e;

endpackage

// File: rtl/rvdp_lt.sv
module rvdp_lt #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            lt_s,
  output logic            lt_u
);
  localparam int MSB = XLEN - 1;

  logic [XLEN:0] diff;

  always_comb begin
    diff = {1'b0, a} - {1'b0, b};
    lt_u = diff[XLEN];
    lt_s = (a[MSB] ^ b[MSB]) ? a[MSB] : diff[MSB];
  end

  always_comb begin
    if (a[MSB] == b[MSB])
      AST_LT_SIGN_AGREE: assert (lt_s == lt_u); // R4
    if (a == b)
      AST_LT_EQUAL_FALSE: assert (!lt_s && !lt_u); // R4
  end

endmodule

// File: rtl/rvdp_alu.sv
module rvdp_alu
  import rvdp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [3:0]      op,
  output logic [XLEN-1:0] y
);
  localparam int SHW = $clog2(XLEN);

  logic            lt_s;
  logic            lt_u;
  logic [SHW-1:0]  shamt;
  alu_op_e         op_e;

  rvdp_lt #(.XLEN(XLEN)) u_lt (
    .a    (a),
    .b    (b),
    .lt_s (lt_s),
    .lt_u (lt_u)
  );

  always_comb begin
    op_e  = alu_op_e'(op);
    shamt = b[SHW-1:0];
    case (op_e)
      OP_ADD:   y = a + b;
      OP_SUB:   y = a - b;
      OP_AND:   y = a & b;
      OP_OR:    y = a | b;
      OP_XOR:   y = a ^ b;
      OP_SHL:   y = a << shamt;
      OP_SHR:   y = a >> shamt;
      OP_SHRA:  y = $signed(a) >>> shamt;
      OP_LTS:   y = {{(XLEN-1){1'b0}}, lt_s};
      OP_LTU:   y = {{(XLEN-1){1'b0}}, lt_u};
      OP_PASSB: y = b;
      default:  y = '0;
    endcase
  end

  always_comb begin
    if ((op == 4'd8) || (op == 4'd9))
      AST_SLT_IS_BOOL: assert (y[XLEN-1:1] == '0); // R4
    if (((op == 4'd0) || (op == 4'd1)) && (b == '0))
      AST_ADDSUB_ZERO: assert (y == a); // R1
    if ((op == 4'd6) && (shamt != '0))
      AST_SHR_ZERO_FILL: assert (y[XLEN-1] == 1'b0); // R3
  end

endmodule

// File: rtl/rvdp_brcmp.sv
module rvdp_brcmp
  import rvdp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [2:0]      cond,
  output logic            taken
);
  logic eq;
  logic lt_s;
  logic lt_u;

  rvdp_lt #(.XLEN(XLEN)) u_lt (
    .a    (a),
    .b    (b),
    .lt_s (lt_s),
    .lt_u (lt_u)
  );

  always_comb begin
    eq = (a == b);
    case (br_cond_e'(cond))
      BC_EQ:   taken = eq;
      BC_NE:   taken = !eq;
      BC_LT:   taken = lt_s;
      BC_GE:   taken = !lt_s;
      BC_LTU:  taken = lt_u;
      BC_GEU:  taken = !lt_u;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    if (cond[2:1] == 2'b01)
      AST_BR_RESERVED: assert (!taken); // R6
    if ((cond == 3'b101) && eq)
      AST_BR_GE_ON_EQ: assert (taken); // R6
  end

endmodule

// File: rtl/rvdp_pcnext.sv
module rvdp_pcnext
  import rvdp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic [1:0]      kind,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] base,
  input  logic            taken,
  output logic [XLEN-1:0] next,
  output logic [XLEN-1:0] link
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] rel_tgt;
  logic [XLEN-1:0] ind_tgt;

  always_comb begin
    link    = pc + STEP;
    rel_tgt = pc + imm;
    ind_tgt = (base + imm) & ~XLEN'(1);
    case (pc_kind_e'(kind))
      PK_SEQ:  next = link;
      PK_BR:   next = taken ? rel_tgt : link;
      PK_JAL:  next = rel_tgt;
      default: next = ind_tgt;
    endcase
  end

  always_comb begin
    if (kind == 2'd3)
      AST_JALR_EVEN: assert (next[0] == 1'b0); // R10
    if ((kind == 2'd1) && !taken)
      AST_BR_FALLTHRU: assert (next == link); // R9
  end

endmodule

// File: rtl/rv_int_datapath.sv
module rv_int_datapath #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] alu_a,
  input  logic [XLEN-1:0] alu_b,
  input  logic [3:0]      alu_op,
  output logic [XLEN-1:0] alu_y,
  input  logic [XLEN-1:0] br_a,
  input  logic [XLEN-1:0] br_b,
  input  logic [2:0]      br_cond,
  output logic            br_taken,
  input  logic [XLEN-1:0] pc,
  input  logic [1:0]      pc_kind,
  input  logic [XLEN-1:0] pc_imm,
  input  logic [XLEN-1:0] jump_base,
  output logic [XLEN-1:0] pc_next,
  output logic [XLEN-1:0] pc_link
);

  rvdp_alu #(.XLEN(XLEN)) u_alu (
    .a  (alu_a),
    .b  (alu_b),
    .op (alu_op),
    .y  (alu_y)
  );

  rvdp_brcmp #(.XLEN(XLEN)) u_brcmp (
    .a     (br_a),
    .b     (br_b),
    .cond  (br_cond),
    .taken (br_taken)
  );

  rvdp_pcnext #(.XLEN(XLEN)) u_pcnext (
    .pc    (pc),
    .kind  (pc_kind),
    .imm   (pc_imm),
    .base  (jump_base),
    .taken (br_taken),
    .next  (pc_next),
    .link  (pc_link)
  );

endmodule

// File: tb/rv_int_datapath_tb.sv
module rv_int_datapath_tb;

  logic        clk;
  logic [31:0] alu_a, alu_b, br_a, br_b, pc, pc_imm, jump_base;
  logic [3:0]  alu_op;
  logic [2:0]  br_cond;
  logic [1:0]  pc_kind;
  logic [31:0] alu_y, pc_next, pc_link;
  logic        br_taken;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  rv_int_datapath u_dut (
    .alu_a(alu_a), .alu_b(alu_b), .alu_op(alu_op), .alu_y(alu_y),
    .br_a(br_a), .br_b(br_b), .br_cond(br_cond), .br_taken(br_taken),
    .pc(pc), .pc_kind(pc_kind), .pc_imm(pc_imm), .jump_base(jump_base),
    .pc_next(pc_next), .pc_link(pc_link)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic alu(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] exp, input string req);
    @(negedge clk);
    alu_op = op; alu_a = a; alu_b = b;
    #1;
    check(req, alu_y, exp);
  endtask

  task automatic br(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                    input logic exp, input string req);
    @(negedge clk);
    br_cond = c; br_a = a; br_b = b;
    #1;
    check(req, {31'd0, br_taken}, {31'd0, exp});
  endtask

  task automatic pcs(input logic [1:0] k, input logic [31:0] p, input logic [31:0] imm,
                     input logic [31:0] base, input logic [31:0] exp, input string req);
    @(negedge clk);
    pc_kind = k; pc = p; pc_imm = imm; jump_base = base;
    #1;
    check(req, pc_next, exp);
    check("R8 link", pc_link, p + 32'd4);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    #1;
    check("R1 idle result", alu_y, 32'h0);
    check("R6 idle equal", {31'd0, br_taken}, 32'd1);
    check("R9 idle next", pc_next, 32'h4);
    check("R8 idle link", pc_link, 32'h4);
  endtask

  task automatic t_addsub();
    alu(4'd0, 32'd5, 32'd7, 32'd12, "R1 add");
    alu(4'd0, 32'hFFFF_FFFF, 32'd1, 32'h0, "R1 add wrap");
    alu(4'd1, 32'd0, 32'd1, 32'hFFFF_FFFF, "R1 sub wrap");
    alu(4'd1, 32'h8000_0000, 32'd1, 32'h7FFF_FFFF, "R1 sub");
  endtask

  task automatic t_logic();
    alu(4'd2, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'h00F0_00F0, "R2 and");
    alu(4'd3, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'hFFF0_FFF0, "R2 or");
    alu(4'd4, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'hFF00_FF00, "R2 xor");
  endtask

  task automatic t_shift();
    alu(4'd5, 32'h1, 32'h21, 32'h2, "R3 shl upper bits ignored");
    alu(4'd6, 32'h8000_0000, 32'h3F, 32'h1, "R3 shr 31 via 0x3F");
    alu(4'd6, 32'h8000_0000, 32'h4, 32'h0800_0000, "R3 shr zero fill");
    alu(4'd7, 32'h8000_0000, 32'h4, 32'hF800_0000, "R3 shra sign fill");
    alu(4'd7, 32'h4000_0000, 32'hFFFF_FFE2, 32'h1000_0000, "R3 shra positive");
  endtask

  task automatic t_slt();
    alu(4'd8, 32'h8000_0000, 32'h7FFF_FFFF, 32'd1, "R4 slt extreme");
    alu(4'd9, 32'h8000_0000, 32'h7FFF_FFFF, 32'd0, "R4 sltu extreme");
    alu(4'd8, 32'h7FFF_FFFF, 32'h8000_0000, 32'd0, "R4 slt extreme rev");
    alu(4'd9, 32'h7FFF_FFFF, 32'h8000_0000, 32'd1, "R4 sltu extreme rev");
    alu(4'd9, 32'd5, 32'hFFFF_F800, 32'd1, "R4 sltiu extended imm");
    alu(4'd8, 32'd5, 32'hFFFF_F800, 32'd0, "R4 slti extended imm");
    alu(4'd8, 32'd9, 32'd9, 32'd0, "R4 slt equal");
  endtask

  task automatic t_pass();
    alu(4'd10, 32'hDEAD_BEEF, 32'h1234_5000, 32'h1234_5000, "R5 lui pass");
    alu(4'd0, 32'h0000_1000, 32'h1234_5000, 32'h1234_6000, "R1 auipc add");
    alu(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R5 unused code");
    alu(4'd11, 32'h1, 32'h1, 32'h0, "R5 unused code 11");
  endtask

  task automatic t_branch();
    br(3'b000, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, "R6 eq");
    br(3'b001, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R6 ne");
    br(3'b100, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R7 lt signed");
    br(3'b101, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, "R7 ge signed");
    br(3'b110, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, "R7 lt unsigned");
    br(3'b111, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R7 ge unsigned");
    br(3'b010, 32'h3, 32'h3, 1'b0, "R6 reserved 010");
    br(3'b011, 32'h3, 32'h4, 1'b0, "R6 reserved 011");
    br(3'b000, 32'h3, 32'h3, 1'b1, "R6 eq equal");
    br(3'b101, 32'h3, 32'h3, 1'b1, "R6 ge equal");
    br(3'b100, 32'h3, 32'h3, 1'b0, "R6 lt equal");
    br(3'b111, 32'h3, 32'h3, 1'b1, "R6 geu equal");
  endtask

  task automatic t_nextpc();
    pcs(2'd0, 32'h100, 32'h40, 32'h0, 32'h104, "R9 sequential");
    br(3'b000, 32'h5, 32'h5, 1'b1, "R6 setup taken");
    pcs(2'd1, 32'h100, 32'hFFFF_FFF0, 32'h0, 32'h0F0, "R9 branch taken back");
    br(3'b001, 32'h5, 32'h5, 1'b0, "R6 setup not taken");
    pcs(2'd1, 32'h100, 32'hFFFF_FFF0, 32'h0, 32'h104, "R9 branch not taken");
    pcs(2'd2, 32'h100, 32'h800, 32'h0, 32'h900, "R9 jal");
  endtask

  task automatic t_jalr();
    pcs(2'd3, 32'h100, 32'h4, 32'h2001, 32'h2004, "R10 jalr clear bit0");
    pcs(2'd3, 32'h100, 32'hFFFF_FFFF, 32'h3000, 32'h2FFE, "R10 jalr neg imm");
    pcs(2'd3, 32'h500, 32'h8, 32'h2000, 32'h2008, "R10 jalr even");
  endtask

  initial begin
    alu_a = '0; alu_b = '0; alu_op = '0;
    br_a = '0; br_b = '0; br_cond = '0;
    pc = '0; pc_kind = '0; pc_imm = '0; jump_base = '0;
    t_reset_state();
    t_addsub();
    t_logic();
    t_shift();
    t_slt();
    t_pass();
    t_branch();
    t_nextpc();
    t_jalr();
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done) begin
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end else if (cycles > 20000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule